// File: doc/BRIEF.md
# One-Hot Residue Arithmetic Unit

This block computes on small residues held in one-hot form. A residue modulo `M` is carried on `M` wires, and wire `i` is high alone when the value is `i`. Modular addition and subtraction use no adder. The unit rotates the data entry around the ring by the amount that the shift entry selects. The shift entry is itself a one-hot residue, so the rotation is an AND-OR barrel structure with one leg per possible amount.

The unit can also XOR two one-hot operands digit-wise, with the result reduced modulo `M`. A load operation turns a binary number into its one-hot form. The registered result always comes with a binary copy of itself and a validity flag. A malformed operand gives no result: when an input that matters is not exactly one-hot, or the binary value is out of range, the outputs are all zero and the flag is low. The default configuration uses modulus 5.

Top module: `ohr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `res_oh` = 0, `res_bin` = 0 and `res_ok` = 0, whatever the other inputs are.
- R2: With `op` = 2'b00 (add), and with `data_oh` and `shift_oh` each having exactly one bit set, the result is the one-hot code of (a + b) mod M. Here a and b are the indices of the set bits (bit i means value i).
- R3: With `op` = 2'b01 (subtract) and both entries one-hot, the result is the one-hot code of (a - b) mod M, which is a downward rotation.
- R4: With `op` = 2'b10 (xor) and both entries one-hot, the result is the one-hot code of (a XOR b) mod M, where XOR is taken on the binary indices.
- R5: With `op` = 2'b11 (load), a value `bin_in` < M gives the one-hot code with bit `bin_in` set. A value `bin_in` >= M gives an invalid result. In this mode `data_oh` and `shift_oh` have no effect.
- R6: For add, subtract and xor, a `data_oh` or `shift_oh` that has zero bits or two or more bits set gives `res_oh` = 0, `res_bin` = 0 and `res_ok` = 0.
- R7: Whenever `res_ok` is high, `res_bin` is the index of the single set bit of `res_oh`, and that bit lies below M.
- R8: Whenever `res_ok` is high, `res_oh` has exactly one bit set. Between two consecutive cycles at most two bits of `res_oh` change.
- R9: Each result appears on the outputs at the first rising edge after its operands are applied. A new result is taken on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 xor, 11 load |
| data_oh | input | M | One-hot data entry |
| shift_oh | input | M | One-hot shift entry (second operand) |
| bin_in | input | W = clog2(M) | Binary value for the load operation |
| res_oh | output | M | Registered one-hot result |
| res_bin | output | W | Registered binary index of the result |
| res_ok | output | 1 | Registered validity flag |

## Verification
The hardest case to reach from the ports is a malformed shift entry paired with a well-formed data entry, and the reverse. In that case only one of the two one-hot checks can reject the operation, so a check that looks at just one entry would go unnoticed. To cover it, the stimulus holds one entry at a legal one-hot value and sweeps the other entry through every bit pattern of its width, for each arithmetic operation. The load operation is also driven with malformed entries, which shows that those entries are ignored in that mode. Every legal operand pair of every operation is compared with integer modular arithmetic.

// File: rtl/ohr_pkg.sv
package ohr_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_XOR  = 2'b10,
    OP_LOAD = 2'b11
  } ohr_op_e;

  localparam int MAX_LINES = 32;

  function automatic logic single_hot(input logic [MAX_LINES-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

endpackage

// File: rtl/ohr_rotator.sv
module ohr_rotator #(
  parameter int M = 5
) (
  input  logic [M-1:0] data_oh,
  input  logic [M-1:0] amt_oh,
  output logic [M-1:0] rot_oh
);

  logic [M-1:0] leg [M];

  for (genvar k = 0; k < M; k++) begin : g_leg
    for (genvar i = 0; i < M; i++) begin : g_bit
      assign leg[k][(i + k) % M] = data_oh[i];
    end
  end

  always_comb begin
    rot_oh = '0;
    for (int k = 0; k < M; k++) begin
      if (amt_oh[k]) rot_oh = rot_oh | leg[k];
    end
  end

endmodule

// File: rtl/ohr_encode.sv
module ohr_encode #(
  parameter int M = 5,
  localparam int W = (M > 1) ? $clog2(M) : 1
) (
  input  logic [M-1:0] oh,
  output logic [W-1:0] bin
);

  always_comb begin
    bin = '0;
    for (int i = 0; i < M; i++) begin
      if (oh[i]) bin = bin | W'(i);
    end
  end

endmodule

// File: rtl/ohr_decode.sv
module ohr_decode #(
  parameter int M = 5,
  localparam int W = (M > 1) ? $clog2(M) : 1
) (
  input  logic [W-1:0] bin,
  output logic [M-1:0] oh,
  output logic         in_range
);

  for (genvar i = 0; i < M; i++) begin : g_line
    assign oh[i] = (bin == W'(i));
  end

  assign in_range = ({1'b0, bin} < (W+1)'(M));

endmodule

// File: rtl/ohr_unit.sv
module ohr_unit #(
  parameter int M = 5,
  localparam int W = (M > 1) ? $clog2(M) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [M-1:0] data_oh,
  input  logic [M-1:0] shift_oh,
  input  logic [W-1:0] bin_in,
  output logic [M-1:0] res_oh,
  output logic [W-1:0] res_bin,
  output logic         res_ok
);
  import ohr_pkg::*;

  ohr_op_e      op_sel;
  logic         data_ok, shift_ok;
  logic [M-1:0] neg_shift;
  logic [M-1:0] sum_oh, diff_oh, xor_oh, load_oh;
  logic [W-1:0] a_bin, b_bin, x_raw, x_mod;
  logic         x_rng, load_rng;
  logic [M-1:0] nxt_oh;
  logic [W-1:0] nxt_bin;
  logic         nxt_ok;

  assign op_sel   = ohr_op_e'(op);
  assign data_ok  = single_hot(MAX_LINES'(data_oh));
  assign shift_ok = single_hot(MAX_LINES'(shift_oh));

  // Additive inverse of the shift amount: line k moves to line (M-k) mod M.
  for (genvar k = 0; k < M; k++) begin : g_neg
    assign neg_shift[(M - k) % M] = shift_oh[k];
  end

  ohr_rotator #(.M(M)) u_rot_up (.data_oh(data_oh), .amt_oh(shift_oh),  .rot_oh(sum_oh));
  ohr_rotator #(.M(M)) u_rot_dn (.data_oh(data_oh), .amt_oh(neg_shift), .rot_oh(diff_oh));

  ohr_encode #(.M(M)) u_enc_a (.oh(data_oh),  .bin(a_bin));
  ohr_encode #(.M(M)) u_enc_b (.oh(shift_oh), .bin(b_bin));

  // a^b < 2^W < 2M, so one conditional subtraction reduces it.
  assign x_raw = a_bin ^ b_bin;
  assign x_mod = ({1'b0, x_raw} >= (W+1)'(M)) ? W'({1'b0, x_raw} - (W+1)'(M)) : x_raw;

  ohr_decode #(.M(M)) u_dec_x (.bin(x_mod),  .oh(xor_oh),  .in_range(x_rng));
  ohr_decode #(.M(M)) u_dec_l (.bin(bin_in), .oh(load_oh), .in_range(load_rng));

  always_comb begin
    nxt_oh = '0;
    nxt_ok = 1'b0;
    unique case (op_sel)
      OP_ADD:  begin nxt_ok = data_ok && shift_ok;         nxt_oh = sum_oh;  end
      OP_SUB:  begin nxt_ok = data_ok && shift_ok;         nxt_oh = diff_oh; end
      OP_XOR:  begin nxt_ok = data_ok && shift_ok && x_rng; nxt_oh = xor_oh; end
      OP_LOAD: begin nxt_ok = load_rng;                    nxt_oh = load_oh; end
      default: begin nxt_ok = 1'b0;                        nxt_oh = '0;      end
    endcase
    if (!nxt_ok) nxt_oh = '0;
  end

  ohr_encode #(.M(M)) u_enc_r (.oh(nxt_oh), .bin(nxt_bin));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_oh  <= '0;
      res_bin <= '0;
      res_ok  <= 1'b0;
    end else begin
      res_oh  <= nxt_oh;
      res_bin <= nxt_bin;
      res_ok  <= nxt_ok;
    end
  end

endmodule

// File: rtl/ohr_unit_chk.sv
module ohr_unit_chk #(
  parameter int M = 5,
  localparam int W = (M > 1) ? $clog2(M) : 1
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op,
  input logic [M-1:0] data_oh,
  input logic [M-1:0] shift_oh,
  input logic [W-1:0] bin_in,
  input logic [M-1:0] res_oh,
  input logic [W-1:0] res_bin,
  input logic         res_ok
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_oh == '0 && !res_ok && res_bin == '0));

  p_add_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b00 && $countones(data_oh) == 1 && shift_oh == M'(1)) |=> (res_ok && res_oh == $past(data_oh)));

  p_sub_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b01 && $countones(data_oh) == 1 && shift_oh == M'(1)) |=> (res_ok && res_oh == $past(data_oh)));

  p_load_range_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11) |=> (res_ok == ($past({1'b0, bin_in}) < (W+1)'(M))));

  p_bad_operand_r6: assert property (@(posedge clk) disable iff (rst)
    (op != 2'b11 && ($countones(data_oh) != 1 || $countones(shift_oh) != 1)) |=> (!res_ok && res_oh == '0));

  p_bin_agrees_r7: assert property (@(posedge clk) disable iff (rst)
    res_ok |-> ({1'b0, res_bin} < (W+1)'(M) && res_oh == (M'(1) << res_bin)));

  p_single_line_r8: assert property (@(posedge clk) disable iff (rst)
    res_ok |-> $countones(res_oh) == 1);

  p_two_toggles_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(res_oh ^ $past(res_oh)) <= 2);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !res_ok |-> (res_oh == '0 && res_bin == '0));

endmodule

bind ohr_unit ohr_unit_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .op(op), .data_oh(data_oh), .shift_oh(shift_oh),
  .bin_in(bin_in), .res_oh(res_oh), .res_bin(res_bin), .res_ok(res_ok)
);

// File: tb/tb_ohr_unit.sv
`timescale 1ns/1ps
module tb_ohr_unit;
  localparam int M = 5;
  localparam int W = $clog2(M);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op = 2'b00;
  logic [M-1:0] data_oh = '0;
  logic [M-1:0] shift_oh = '0;
  logic [W-1:0] bin_in = '0;
  logic [M-1:0] res_oh;
  logic [W-1:0] res_bin;
  logic         res_ok;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [M-1:0] prev_oh = '0;

  always #2.5 clk = ~clk;

  ohr_unit #(.M(M)) dut (
    .clk(clk), .rst(rst), .op(op), .data_oh(data_oh), .shift_oh(shift_oh),
    .bin_in(bin_in), .res_oh(res_oh), .res_bin(res_bin), .res_ok(res_ok)
  );

  function automatic int popc(input logic [M-1:0] v);
    int n = 0;
    for (int i = 0; i < M; i++) n += int'(v[i]);
    return n;
  endfunction

  // Apply at a falling edge, sample at the next falling edge (one register).
  task automatic apply(input logic [1:0] o, input logic [M-1:0] d, input logic [M-1:0] s,
                       input logic [W-1:0] b);
    op = o; data_oh = d; shift_oh = s; bin_in = b;
    @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input bit ok, input int val);
    logic [M-1:0] eoh;
    logic [W-1:0] ebin;
    eoh  = ok ? (M'(1) << val) : '0;
    ebin = ok ? W'(val) : '0;
    checks++;
    if (res_ok !== ok || res_oh !== eoh || res_bin !== ebin) begin
      failures++;
      $display("FAIL %s op=%0d data=%b shift=%b bin=%0d: got ok=%b oh=%b bin=%0d expected ok=%b oh=%b bin=%0d",
               tag, op, data_oh, shift_oh, bin_in, res_ok, res_oh, res_bin, ok, eoh, ebin);
    end
    checks++;
    if (popc(res_oh ^ prev_oh) > 2) begin
      failures++;
      $display("FAIL R8 toggles: got %0d lines changed expected <=2", popc(res_oh ^ prev_oh));
    end
    prev_oh = res_oh;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates even with a legal load on the inputs
    op = 2'b11; bin_in = 3'd2; data_oh = 5'b00010; shift_oh = 5'b00100;
    repeat (3) @(negedge clk);
    expect_res("R1", 0, 0);
    rst = 1'b0;

    // R2, R3, R4, R9: every legal operand pair, result one cycle later
    for (int o = 0; o < 3; o++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          int e;
          apply(2'(o), M'(1) << a, M'(1) << b, '0);
          case (o)
            0: e = (a + b) % M;
            1: e = (a - b + M) % M;
            default: e = (a ^ b) % M;
          endcase
          expect_res(o == 0 ? "R2" : (o == 1 ? "R3" : "R4"), 1, e);
        end
      end
    end

    // R5: load of every binary value, with malformed entries that must be ignored
    for (int v = 0; v < (1 << W); v++) begin
      apply(2'b11, 5'b11011, 5'b00000, W'(v));
      expect_res("R5", v < M, v);
    end

    // R6: malformed shift entry with legal data, then the reverse
    for (int o = 0; o < 3; o++) begin
      for (int p = 0; p < (1 << M); p++) begin
        if (popc(M'(p)) != 1) begin
          apply(2'(o), 5'b00100, M'(p), '0);
          expect_res("R6", 0, 0);
          apply(2'(o), M'(p), 5'b00010, '0);
          expect_res("R6", 0, 0);
        end
      end
    end

    // R7/R9: recover from invalid to valid in one cycle
    apply(2'b00, 5'b10000, 5'b10000, '0);
    expect_res("R7", 1, 3);
    apply(2'b01, 5'b00001, 5'b00010, '0);
    expect_res("R9", 1, 4);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule